// File: doc/BRIEF.md
# Function Configuration Header Register File

This block holds the 64-byte type-0 configuration header of one device function. It sits behind a simple register-access port that a bus front end drives. Each access carries a byte offset, a byte count of 1, 2 or 4, write data and a read/write select. One clock later the block returns the read data and an error flag. Identification fields, status, the interrupt pin and the grant and latency fields are fixed when the block is elaborated. Command, cache line size, latency timer, interrupt line and the expansion ROM base can be written by software.

Six base address registers (BARs) each have their own size parameter. Writing all ones to a BAR probes its size: the BAR then reads back as a mask of the address bits it decodes. Bit 0 of a BAR selects its kind. A 1 marks an I/O BAR, whose low two bits are read-only. A 0 marks a memory BAR, whose low four bits are read-only. The expansion ROM register answers its own probe value.

For every BAR that has been given a non-zero base address, the block drives a valid bit and the base address with the type bits cleared. A downstream address decoder uses these outputs.

Top module: `cfg_header_regs`

## Requirements
- R1: An access whose bytes reach offset 0x40 or beyond (offset plus byte count above 64) sets the error flag and changes no state. No access sets the error flag in the cycle after an idle cycle.
- R2: A read with a byte count of 1, 2 or 4 returns the header bytes starting at the offset, least significant byte first, zero-extended to 32 bits. It may start at any offset. Any other byte count sets the error flag. Read data and the error flag appear in the cycle after the access, and read data is zero whenever the error flag is set.
- R3: A 1-byte write is accepted at 0x0C (cache line size), 0x0D (latency timer) and 0x3C (interrupt line). At any other offset it sets the error flag and changes nothing.
- R4: A 2-byte write at 0x04 loads the command field. A 2-byte write at 0x0C loads cache line size from bits 7:0 and latency timer from bits 15:8. Any other 2-byte write sets the error flag.
- R5: A write with a byte count of 3, 0, 5, 6 or 7 sets the error flag and changes nothing.
- R6: A 4-byte write of 0xFFFFFFFF to a BAR (offset 0x10 + 4*n, n = 0..5) loads it with the complement of (size - 1), with its read-only low bits kept.
- R7: If bit 0 of a BAR is 1, its bits 1:0 never change. If bit 0 is 0, its bits 3:0 never change. Any other 4-byte BAR write stores the written value in the remaining bits.
- R8: A 4-byte write of 0xFFFFFFFE at 0x30 makes the ROM base read 0xFFFFFFFF. Any other 4-byte value there is stored as written.
- R9: A 4-byte write at 0x04 loads the command field from bits 15:0. The status field at 0x06 keeps its parameter value.
- R10: A 4-byte write at any offset other than 0x04, 0x30 or an aligned BAR offset sets the error flag and changes nothing.
- R11: A BAR whose size parameter is zero always reads zero. Writes to it are accepted without error and have no effect.
- R12: A BAR's valid output rises after a non-probe write whose bits above the read-only type bits are non-zero. It falls after a probe or after a write whose base bits are zero. Its base output is the BAR value with the type bits cleared, and it is non-zero while valid is high.
- R13: Reset loads every field from its parameter, clears all valid outputs, the error flag and the read data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_offset | input | 8 | Byte offset of the access |
| acc_size | input | 3 | Byte count (1, 2 or 4 legal) |
| acc_wdata | input | 32 | Write data, lowest byte at the offset |
| rsp_rdata | output | 32 | Read data, valid the cycle after a read |
| rsp_err | output | 1 | Error flag for the previous cycle's access |
| bar_valid | output | NUM_BARS | Per-BAR base programmed |
| bar_base | output | NUM_BARS*32 | Per-BAR base address, type bits cleared |

## Verification
The assertions check on every cycle that BAR type bits never move, that a probe always leaves the size mask in the decoding bits, and that an armed BAR carries a non-zero base. They also check that out-of-range, 3-byte and misplaced byte writes raise the flag, that the flag never follows an idle cycle, and that the ROM probe value reads back as all ones. Only the bench's scenarios can show the little-endian byte placement of unaligned and narrow reads. The same holds for the split of a 2-byte write across cache line size and latency timer, for the rejected accesses leaving every field untouched, and for valid following the order of base writes and probes across several BARs.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    localparam int NUM_BARS  = 6;
    localparam int BAR_W     = 32;
    localparam int HDR_BYTES = 64;

    localparam logic [7:0] OFF_CMD   = 8'h04;
    localparam logic [7:0] OFF_CLS   = 8'h0C;
    localparam logic [7:0] OFF_LAT   = 8'h0D;
    localparam logic [7:0] OFF_BAR0  = 8'h10;
    localparam logic [7:0] OFF_ROM   = 8'h30;
    localparam logic [7:0] OFF_LINE  = 8'h3C;

    localparam logic [31:0] ROM_PROBE = 32'hFFFF_FFFE;

    // one-hot write targets plus the error verdict of an access
    typedef struct packed {
        logic                cmd;
        logic                cls;
        logic                lat_lo;
        logic                lat_hi;
        logic                line;
        logic                rom;
        logic [NUM_BARS-1:0] bar;
        logic                err;
    } wr_sel_t;

    typedef struct packed {
        logic [BAR_W-1:0] val;
        logic             armed;
    } bar_state_t;

    typedef struct packed {
        logic [15:0] cmd;
        logic [7:0]  cls;
        logic [7:0]  lat;
        logic [7:0]  line;
        logic [31:0] rom;
        logic [31:0] rdata;
        logic        err;
    } hdr_state_t;

endpackage

// File: rtl/cfg_access_decode.sv
module cfg_access_decode
    import cfg_hdr_pkg::*;
(
    input  logic       valid,
    input  logic       write,
    input  logic [7:0] offset,
    input  logic [2:0] size,
    output wr_sel_t    sel
);

    logic end_ok;
    logic size_ok;

    always_comb begin
        sel     = '0;
        end_ok  = ({1'b0, offset} + {6'd0, size}) <= 9'(HDR_BYTES);
        size_ok = (size == 3'd1) || (size == 3'd2) || (size == 3'd4);
        if (valid) begin
            if (!size_ok || !end_ok) begin
                sel.err = 1'b1;
            end else if (write) begin
                case (size)
                    3'd1: begin
                        if (offset == OFF_CLS)       sel.cls    = 1'b1;
                        else if (offset == OFF_LAT)  sel.lat_lo = 1'b1;
                        else if (offset == OFF_LINE) sel.line   = 1'b1;
                        else                         sel.err    = 1'b1;
                    end
                    3'd2: begin
                        if (offset == OFF_CMD) begin
                            sel.cmd = 1'b1;
                        end else if (offset == OFF_CLS) begin
                            sel.cls    = 1'b1;
                            sel.lat_hi = 1'b1;
                        end else begin
                            sel.err = 1'b1;
                        end
                    end
                    default: begin
                        if (offset == OFF_CMD) begin
                            sel.cmd = 1'b1;
                        end else if (offset == OFF_ROM) begin
                            sel.rom = 1'b1;
                        end else begin
                            for (int i = 0; i < NUM_BARS; i++) begin
                                if (offset == 8'(int'(OFF_BAR0) + 4 * i))
                                    sel.bar[i] = 1'b1;
                            end
                            if (sel.bar == '0)
                                sel.err = 1'b1;
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import cfg_hdr_pkg::*;
(
    input  logic [HDR_BYTES*8-1:0] image,
    input  logic [5:0]             offset,
    input  logic [2:0]             size,
    output logic [31:0]            data
);

    logic [HDR_BYTES*8-1:0] shifted;

    always_comb begin
        shifted = image >> {offset, 3'b000};
        case (size)
            3'd1:    data = {24'd0, shifted[7:0]};
            3'd2:    data = {16'd0, shifted[15:0]};
            3'd4:    data = shifted[31:0];
            default: data = '0;
        endcase
    end

endmodule

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot
    import cfg_hdr_pkg::*;
#(
    parameter logic [BAR_W-1:0] SIZE = 32'h0000_1000,
    parameter logic [BAR_W-1:0] INIT = 32'h0000_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BAR_W-1:0] wdata,
    output logic [BAR_W-1:0] value,
    output logic [BAR_W-1:0] base,
    output logic             valid
);

    localparam logic             PRESENT   = (SIZE != '0);
    localparam logic [BAR_W-1:0] SIZE_MASK = SIZE - 1'b1;
    localparam logic [BAR_W-1:0] RST_VAL   = PRESENT ? INIT : '0;

    bar_state_t       state_d, state_q;
    logic [BAR_W-1:0] keep;
    logic             probe;

    // type bits come from the stored value: I/O keeps 2, memory keeps 4
    assign keep  = state_q.val[0] ? 32'h0000_0003 : 32'h0000_000F;
    assign probe = &wdata;

    always_comb begin
        state_d = state_q;
        if (PRESENT && wr_en) begin
            if (probe) begin
                state_d.val   = ~SIZE_MASK | (state_q.val & keep);
                state_d.armed = 1'b0;
            end else begin
                state_d.val   = (wdata & ~keep) | (state_q.val & keep);
                state_d.armed = |(wdata & ~keep);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.val   <= RST_VAL;
            state_q.armed <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign value = state_q.val;
    assign base  = state_q.val & ~keep;
    assign valid = state_q.armed;

    p_probe_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (PRESENT && wr_en && probe) |=> ((state_q.val & ~keep) == (~SIZE_MASK & ~keep)));

    p_io_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(state_q.val[1:0]));

    p_mem_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !state_q.val[0] |=> $stable(state_q.val[3:0]));

    p_armed_base_r12: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (base != '0));

endmodule

// File: rtl/cfg_header_regs.sv
module cfg_header_regs
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0]              VENDOR_ID     = 16'hCAFE,
    parameter logic [15:0]              DEVICE_ID     = 16'h0A51,
    parameter logic [15:0]              CMD_RESET     = 16'h0000,
    parameter logic [15:0]              STATUS_VAL    = 16'h0210,
    parameter logic [7:0]               REVISION      = 8'h03,
    parameter logic [23:0]              CLASS_CODE    = 24'h020000,
    parameter logic [7:0]               CLS_RESET     = 8'h00,
    parameter logic [7:0]               LAT_RESET     = 8'h00,
    parameter logic [7:0]               HEADER_TYPE   = 8'h00,
    parameter logic [7:0]               BIST_VAL      = 8'h00,
    parameter logic [31:0]              CIS_PTR       = 32'h0000_0000,
    parameter logic [15:0]              SUBSYS_VENDOR = 16'h1234,
    parameter logic [15:0]              SUBSYS_ID     = 16'h5678,
    parameter logic [31:0]              ROM_RESET     = 32'h0000_0000,
    parameter logic [7:0]               LINE_RESET    = 8'hFF,
    parameter logic [7:0]               INT_PIN       = 8'h01,
    parameter logic [7:0]               MIN_GRANT     = 8'h00,
    parameter logic [7:0]               MAX_LATENCY   = 8'h00,
    parameter logic [NUM_BARS*BAR_W-1:0] BAR_INIT     =
        {32'h0, 32'h0, 32'h0, 32'h8, 32'h1, 32'h0},
    parameter logic [NUM_BARS*BAR_W-1:0] BAR_SIZE     =
        {32'h0, 32'h10, 32'h0, 32'h1_0000, 32'h100, 32'h1000}
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      acc_valid,
    input  logic                      acc_write,
    input  logic [7:0]                acc_offset,
    input  logic [2:0]                acc_size,
    input  logic [31:0]               acc_wdata,
    output logic [31:0]               rsp_rdata,
    output logic                      rsp_err,
    output logic [NUM_BARS-1:0]       bar_valid,
    output logic [NUM_BARS*BAR_W-1:0] bar_base
);

    localparam int RSVD_BYTES = 8;

    wr_sel_t                   sel;
    hdr_state_t                h_d, h_q;
    logic [BAR_W-1:0]          bar_val [NUM_BARS];
    logic [NUM_BARS*BAR_W-1:0] bar_vec;
    logic [HDR_BYTES*8-1:0]    image;
    logic [31:0]               mux_data;

    cfg_access_decode u_dec (
        .valid  (acc_valid),
        .write  (acc_write),
        .offset (acc_offset),
        .size   (acc_size),
        .sel    (sel)
    );

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
        cfg_bar_slot #(
            .SIZE (BAR_SIZE[g*BAR_W +: BAR_W]),
            .INIT (BAR_INIT[g*BAR_W +: BAR_W])
        ) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (sel.bar[g]),
            .wdata (acc_wdata),
            .value (bar_val[g]),
            .base  (bar_base[g*BAR_W +: BAR_W]),
            .valid (bar_valid[g])
        );
    end

    always_comb begin
        for (int i = 0; i < NUM_BARS; i++)
            bar_vec[i*BAR_W +: BAR_W] = bar_val[i];
    end

    // header image, highest byte (0x3F) on the left
    assign image = {MAX_LATENCY, MIN_GRANT, INT_PIN, h_q.line,
                    {RSVD_BYTES{8'h00}},
                    h_q.rom, SUBSYS_ID, SUBSYS_VENDOR, CIS_PTR,
                    bar_vec,
                    BIST_VAL, HEADER_TYPE, h_q.lat, h_q.cls,
                    CLASS_CODE, REVISION,
                    STATUS_VAL, h_q.cmd,
                    DEVICE_ID, VENDOR_ID};

    cfg_read_mux u_mux (
        .image  (image),
        .offset (acc_offset[5:0]),
        .size   (acc_size),
        .data   (mux_data)
    );

    always_comb begin
        h_d       = h_q;
        h_d.err   = sel.err;
        h_d.rdata = (acc_valid && !acc_write && !sel.err) ? mux_data : '0;
        if (sel.cmd)    h_d.cmd  = acc_wdata[15:0];
        if (sel.cls)    h_d.cls  = acc_wdata[7:0];
        if (sel.lat_lo) h_d.lat  = acc_wdata[7:0];
        if (sel.lat_hi) h_d.lat  = acc_wdata[15:8];
        if (sel.line)   h_d.line = acc_wdata[7:0];
        if (sel.rom)    h_d.rom  = (acc_wdata == ROM_PROBE) ? '1 : acc_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q.cmd   <= CMD_RESET;
            h_q.cls   <= CLS_RESET;
            h_q.lat   <= LAT_RESET;
            h_q.line  <= LINE_RESET;
            h_q.rom   <= ROM_RESET;
            h_q.rdata <= '0;
            h_q.err   <= 1'b0;
        end else begin
            h_q <= h_d;
        end
    end

    assign rsp_rdata = h_q.rdata;
    assign rsp_err   = h_q.err;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_err);

    p_high_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_offset >= 8'h40) |=> rsp_err);

    p_err_zero_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0));

    p_ro_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_size == 3'd1 && acc_offset != OFF_CLS &&
         acc_offset != OFF_LAT && acc_offset != OFF_LINE) |=> rsp_err);

    p_three_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_size == 3'd3) |=> rsp_err);

    p_rom_probe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_size == 3'd4 && acc_offset == OFF_ROM &&
         acc_wdata == ROM_PROBE) |=> (h_q.rom == 32'hFFFF_FFFF));

endmodule

// File: tb/cfg_header_regs_test.sv
module cfg_header_regs_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         acc_valid = 1'b0;
    logic         acc_write = 1'b0;
    logic [7:0]   acc_offset = '0;
    logic [2:0]   acc_size = '0;
    logic [31:0]  acc_wdata = '0;
    logic [31:0]  rsp_rdata;
    logic         rsp_err;
    logic [5:0]   bar_valid;
    logic [191:0] bar_base;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cfg_header_regs uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_offset (acc_offset),
        .acc_size   (acc_size),
        .acc_wdata  (acc_wdata),
        .rsp_rdata  (rsp_rdata),
        .rsp_err    (rsp_err),
        .bar_valid  (bar_valid),
        .bar_base   (bar_base)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  off;
        logic [2:0]  sz;
        logic [31:0] wd;
        logic [31:0] exp;
        logic        err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 60;
    localparam vec_t VECS [NV] = '{
        // R13 reset contents
        '{1'b0, 8'h00, 3'd4, 32'h0, 32'h0A51CAFE, 1'b0, 4'd13},
        '{1'b0, 8'h04, 3'd4, 32'h0, 32'h02100000, 1'b0, 4'd13},
        '{1'b0, 8'h08, 3'd4, 32'h0, 32'h02000003, 1'b0, 4'd13},
        '{1'b0, 8'h14, 3'd4, 32'h0, 32'h00000001, 1'b0, 4'd13},
        '{1'b0, 8'h18, 3'd4, 32'h0, 32'h00000008, 1'b0, 4'd13},
        '{1'b0, 8'h2C, 3'd4, 32'h0, 32'h56781234, 1'b0, 4'd13},
        '{1'b0, 8'h3C, 3'd4, 32'h0, 32'h000001FF, 1'b0, 4'd13},
        // R2 narrow reads and bad size
        '{1'b0, 8'h02, 3'd2, 32'h0, 32'h00000A51, 1'b0, 4'd2},
        '{1'b0, 8'h01, 3'd1, 32'h0, 32'h000000CA, 1'b0, 4'd2},
        '{1'b0, 8'h0B, 3'd1, 32'h0, 32'h00000002, 1'b0, 4'd2},
        '{1'b0, 8'h00, 3'd3, 32'h0, 32'h0,        1'b1, 4'd2},
        // R1 out of range
        '{1'b0, 8'h3E, 3'd4, 32'h0, 32'h0,        1'b1, 4'd1},
        '{1'b0, 8'h40, 3'd1, 32'h0, 32'h0,        1'b1, 4'd1},
        '{1'b1, 8'h44, 3'd4, 32'hFFFFFFFF, 32'h0, 1'b1, 4'd1},
        // R3 byte writes
        '{1'b1, 8'h0C, 3'd1, 32'h10, 32'h0,       1'b0, 4'd3},
        '{1'b1, 8'h3C, 3'd1, 32'h0B, 32'h0,       1'b0, 4'd3},
        '{1'b1, 8'h00, 3'd1, 32'h55, 32'h0,       1'b1, 4'd3},
        '{1'b1, 8'h3D, 3'd1, 32'h07, 32'h0,       1'b1, 4'd3},
        '{1'b0, 8'h0C, 3'd4, 32'h0, 32'h00000010, 1'b0, 4'd3},
        '{1'b0, 8'h3C, 3'd4, 32'h0, 32'h0000010B, 1'b0, 4'd3},
        // R4 half writes
        '{1'b1, 8'h0C, 3'd2, 32'h4020, 32'h0,     1'b0, 4'd4},
        '{1'b0, 8'h0C, 3'd4, 32'h0, 32'h00004020, 1'b0, 4'd4},
        '{1'b1, 8'h04, 3'd2, 32'h0007, 32'h0,     1'b0, 4'd4},
        '{1'b1, 8'h08, 3'd2, 32'h0001, 32'h0,     1'b1, 4'd4},
        '{1'b0, 8'h04, 3'd4, 32'h0, 32'h02100007, 1'b0, 4'd4},
        // R9 word write to command
        '{1'b1, 8'h04, 3'd4, 32'hFFFF0146, 32'h0, 1'b0, 4'd9},
        '{1'b0, 8'h04, 3'd4, 32'h0, 32'h02100146, 1'b0, 4'd9},
        '{1'b0, 8'h02, 3'd4, 32'h0, 32'h01460A51, 1'b0, 4'd2},
        // R5 illegal write sizes
        '{1'b1, 8'h0C, 3'd3, 32'h00FFFFFF, 32'h0, 1'b1, 4'd5},
        '{1'b1, 8'h0C, 3'd0, 32'h0, 32'h0,        1'b1, 4'd5},
        '{1'b1, 8'h0C, 3'd6, 32'h0, 32'h0,        1'b1, 4'd5},
        '{1'b0, 8'h0C, 3'd4, 32'h0, 32'h00004020, 1'b0, 4'd5},
        // R6 size probes
        '{1'b1, 8'h10, 3'd4, 32'hFFFFFFFF, 32'h0, 1'b0, 4'd6},
        '{1'b0, 8'h10, 3'd4, 32'h0, 32'hFFFFF000, 1'b0, 4'd6},
        '{1'b1, 8'h14, 3'd4, 32'hFFFFFFFF, 32'h0, 1'b0, 4'd6},
        '{1'b0, 8'h14, 3'd4, 32'h0, 32'hFFFFFF01, 1'b0, 4'd6},
        '{1'b1, 8'h18, 3'd4, 32'hFFFFFFFF, 32'h0, 1'b0, 4'd6},
        '{1'b0, 8'h18, 3'd4, 32'h0, 32'hFFFF0008, 1'b0, 4'd6},
        // R7 base writes keep type bits
        '{1'b1, 8'h10, 3'd4, 32'hC000000F, 32'h0, 1'b0, 4'd7},
        '{1'b0, 8'h10, 3'd4, 32'h0, 32'hC0000000, 1'b0, 4'd7},
        '{1'b1, 8'h14, 3'd4, 32'h0000D002, 32'h0, 1'b0, 4'd7},
        '{1'b0, 8'h14, 3'd4, 32'h0, 32'h0000D001, 1'b0, 4'd7},
        // R11 absent BAR
        '{1'b1, 8'h1C, 3'd4, 32'hFFFFFFFF, 32'h0, 1'b0, 4'd11},
        '{1'b0, 8'h1C, 3'd4, 32'h0, 32'h0,        1'b0, 4'd11},
        '{1'b1, 8'h1C, 3'd4, 32'h12340000, 32'h0, 1'b0, 4'd11},
        '{1'b0, 8'h1C, 3'd4, 32'h0, 32'h0,        1'b0, 4'd11},
        // R8 ROM base
        '{1'b1, 8'h30, 3'd4, 32'hFFFFFFFE, 32'h0, 1'b0, 4'd8},
        '{1'b0, 8'h30, 3'd4, 32'h0, 32'hFFFFFFFF, 1'b0, 4'd8},
        '{1'b1, 8'h30, 3'd4, 32'h000A0001, 32'h0, 1'b0, 4'd8},
        '{1'b0, 8'h30, 3'd4, 32'h0, 32'h000A0001, 1'b0, 4'd8},
        // R10 other word writes
        '{1'b1, 8'h08, 3'd4, 32'h12345678, 32'h0, 1'b1, 4'd10},
        '{1'b1, 8'h12, 3'd4, 32'h0, 32'h0,        1'b1, 4'd10},
        '{1'b0, 8'h10, 3'd4, 32'h0, 32'hC0000000, 1'b0, 4'd10},
        '{1'b0, 8'h08, 3'd4, 32'h0, 32'h02000003, 1'b0, 4'd10},
        // R12 zero base write to BAR4
        '{1'b1, 8'h20, 3'd4, 32'h0, 32'h0,        1'b0, 4'd12},
        '{1'b0, 8'h20, 3'd4, 32'h0, 32'h0,        1'b0, 4'd12},
        '{1'b1, 8'h20, 3'd4, 32'hFFFFFFFF, 32'h0, 1'b0, 4'd6},
        '{1'b0, 8'h20, 3'd4, 32'h0, 32'hFFFFFFF0, 1'b0, 4'd6},
        '{1'b0, 8'h3C, 3'd2, 32'h0, 32'h0000010B, 1'b0, 4'd2},
        '{1'b0, 8'h0D, 3'd1, 32'h0, 32'h00000040, 1'b0, 4'd4}
    };

    task automatic check(input string req, input logic [191:0] act, input logic [191:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // drive one access for one cycle, return at the following negedge
    task automatic access(input logic wr, input logic [7:0] off, input logic [2:0] sz,
                          input logic [31:0] wd);
        @(negedge clk);
        acc_valid  = 1'b1;
        acc_write  = wr;
        acc_offset = off;
        acc_size   = sz;
        acc_wdata  = wd;
        @(negedge clk);
        acc_valid  = 1'b0;
        acc_write  = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R13 outputs after reset
        check("R13", {191'd0, rsp_err}, 192'd0);
        check("R13", {160'd0, rsp_rdata}, 192'd0);
        check("R13", {186'd0, bar_valid}, 192'd0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].off, VECS[i].sz, VECS[i].wd);
            check($sformatf("R%0d vec %0d data", VECS[i].req, i),
                  {160'd0, rsp_rdata}, {160'd0, VECS[i].exp});
            check($sformatf("R%0d vec %0d err", VECS[i].req, i),
                  {191'd0, rsp_err}, {191'd0, VECS[i].err});
        end

        // R12 BAR0 and BAR1 programmed, BAR2 and BAR4 probed, others absent
        check("R12", {186'd0, bar_valid}, {186'd0, 6'b000011});
        check("R12", {160'd0, bar_base[31:0]}, {160'd0, 32'hC0000000});
        check("R12", {160'd0, bar_base[63:32]}, {160'd0, 32'h0000D000});

        // R12 a probe withdraws BAR0
        access(1'b1, 8'h10, 3'd4, 32'hFFFFFFFF);
        check("R12", {186'd0, bar_valid}, {186'd0, 6'b000010});

        // R12 zero base withdraws BAR1, type bit kept (R7)
        access(1'b1, 8'h14, 3'd4, 32'h0);
        check("R12", {186'd0, bar_valid}, 192'd0);
        access(1'b0, 8'h14, 3'd4, 32'h0);
        check("R7", {160'd0, rsp_rdata}, {160'd0, 32'h1});

        // R1 idle cycle after an error leaves the flag low
        access(1'b0, 8'h50, 3'd4, 32'h0);
        check("R1", {191'd0, rsp_err}, {191'd0, 1'b1});
        @(negedge clk);
        check("R1", {191'd0, rsp_err}, 192'd0);

        // R13 reset in mid-run restores parameter values
        access(1'b1, 8'h14, 3'd4, 32'h00004000);
        check("R12", {186'd0, bar_valid}, {186'd0, 6'b000010});
        do_reset();
        check("R13", {186'd0, bar_valid}, 192'd0);
        access(1'b0, 8'h0C, 3'd4, 32'h0);
        check("R13", {160'd0, rsp_rdata}, 192'd0);
        access(1'b0, 8'h30, 3'd4, 32'h0);
        check("R13", {160'd0, rsp_rdata}, 192'd0);
        access(1'b0, 8'h10, 3'd4, 32'h0);
        check("R13", {160'd0, rsp_rdata}, 192'd0);
        access(1'b0, 8'h3C, 3'd1, 32'h0);
        check("R13", {160'd0, rsp_rdata}, {160'd0, 32'hFF});

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule